// File: doc/BRIEF.md
# Quad-Input Page Program Receiver

This block is the device-side receiver for a serial NOR flash page program command that moves its address and data over four lines. While chip select is low it counts rising serial clock edges. The eight command bits arrive on line 0 alone. The 24-bit address then arrives four bits per edge, and after it the data bytes, two edges per byte. For each complete data byte the block sends the page buffer a one-cycle write strobe with a byte address. The write data is the byte ANDed with the value the buffer already holds, so a program can only clear bits.

The block runs on a fast system clock. It treats the serial clock, chip select and the four data lines as synchronous inputs and finds serial clock rising edges by comparing each sample with the one before. The write-enable latch, the quad-enable bit and the protection-select bit are level inputs. Two lock inputs return the block-protect and sector-protect state for the address shown on `lock_addr`. When chip select rises after at least one byte was written, the block pulses a request to clear the write-enable latch.

The controller has seven states. S_IDLE waits for chip select to go low. S_CMD takes the eight command bits. S_ADDR takes the six address nibbles. S_CHECK lasts one system cycle and tests the preconditions. S_DHI and S_DLO take the high and low nibble of each data byte. S_SKIP ignores the rest of a rejected frame. The transitions are:
- S_IDLE→S_CMD when chip select is low.
- S_CMD→S_ADDR on the eighth bit when the code matches, and S_CMD→S_SKIP when it does not.
- S_ADDR→S_CHECK on the sixth nibble.
- S_CHECK→S_DHI when the write is accepted, and S_CHECK→S_SKIP when it is not.
- S_DHI→S_DLO and S_DLO→S_DHI on each edge.
- Any state goes to S_IDLE when chip select is high.

Top module: `quad_prog_rx`

## Requirements
- R1: After reset, `wr_en` and `wel_clr` are 0.
- R2: The command is 8 bits sampled from `sio[0]` on successive rising `sclk` edges, most significant bit first. Only code 0x38 leads to writes. Any other code produces no write and no `wel_clr` for the rest of the frame, and `sio[3:1]` are ignored during the command.
- R3: The address is 6 nibbles taken one per rising edge, most significant nibble first. Within each nibble, `sio[3]` is the highest bit, so the first nibble is A23..A20.
- R4: Each data byte takes two rising edges. The first edge carries bits 7..4 and the second carries bits 3..0, with `sio[n]` as bit n of the nibble. `wr_en` is high for exactly one system cycle per complete byte.
- R5: `wr_data` equals `buf_old & byte`, where `buf_old` is the buffer's current content at `wr_addr`.
- R6: The first byte is written at the received address. Each later byte increments `wr_addr[7:0]` by one modulo 256, and `wr_addr[23:8]` stays fixed.
- R7: If `wel_i` is 0 when the address completes, the frame produces no write.
- R8: If `qe_i` is 0 when the address completes, the frame produces no write.
- R9: The page is locked when `sec_lock` is 1 with `prot_sel` set to 1, or when `blk_lock` is 1 with `prot_sel` set to 0. A locked page receives no write. The lock not selected by `prot_sel` has no effect.
- R10: A chip select rise during the command or address phase ends the frame with no write and no `wel_clr`.
- R11: A chip select rise ends the frame and discards any trailing partial byte. `wel_clr` pulses for one cycle if and only if at least one byte was written in that frame.
- R12: Frames behave the same whether `sclk` idles low (mode 0) or idles high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock level, sampled by `clk` |
| sio | input | 4 | Serial data lines |
| wel_i | input | 1 | Write-enable latch state |
| qe_i | input | 1 | Quad-enable configuration bit |
| prot_sel | input | 1 | Selects the lock source: 0 for block lock, 1 for sector lock |
| blk_lock | input | 1 | Block-protect lock for `lock_addr` |
| sec_lock | input | 1 | Sector-protect lock for `lock_addr` |
| buf_old | input | 8 | Current page buffer content at `wr_addr` |
| lock_addr | output | 24 | Address being assembled or addressed, used for the lock lookup |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 24 | Byte address of the write |
| wr_data | output | 8 | Data to store: the old content ANDed with the received byte |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
The bench sweeps all 32 combinations of write-enable, quad-enable, protection select and the two lock inputs in one-byte frames. This tells each gating term apart from the others and shows that the lock not selected has no effect. A 256-byte frame that starts in the middle of a page uses a different byte value at every position, so any fault in nibble order, line order, address wrap or upper-bit hold shows up. A second frame over a preset buffer pattern separates a straight write from the AND merge. Wrong command codes, frames cut short in the command and address phases, frames with a trailing half byte and frames with no data bytes separate abort handling from `wel_clr`, and both clock idle levels are used.

// File: rtl/quad_prog_rx_pkg.sv
package quad_prog_rx_pkg;

    localparam logic [7:0] QPP_CMD   = 8'h38;
    localparam int         CMD_BITS  = 8;
    localparam int         ADDR_NIBS = 6;
    localparam int         CNT_W     = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_ADDR,
        S_CHECK,
        S_DHI,
        S_DLO,
        S_SKIP
    } rx_state_e;

endpackage

// File: rtl/quad_prog_rx_edge.sv
module quad_prog_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic sclk_rise
);

    logic sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign sclk_rise = sclk & ~sclk_q;

    // R4: a rise is never reported on two consecutive cycles
    p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> !sclk_rise);

endmodule

// File: rtl/quad_prog_rx_addr.sv
module quad_prog_rx_addr #(
    parameter int ADDR_W = 24,
    parameter int PAGE_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NIB_W-1:0]  nib,
    input  logic              advance,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int KEEP_W = ADDR_W - NIB_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (load) begin
            cur_addr <= {cur_addr[KEEP_W-1:0], nib};
        end else if (advance) begin
            cur_addr[PAGE_W-1:0] <= cur_addr[PAGE_W-1:0] + 1'b1;
        end
    end

    // R6: stepping changes only the in-page offset, modulo the page size
    p_page_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> $stable(cur_addr[ADDR_W-1:PAGE_W]));

    p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=>
            (cur_addr[PAGE_W-1:0] == PAGE_W'($past(cur_addr[PAGE_W-1:0]) + 1'b1)));

endmodule

// File: rtl/quad_prog_rx_gate.sv
module quad_prog_rx_gate (
    input  logic wel_i,
    input  logic qe_i,
    input  logic prot_sel,
    input  logic blk_lock,
    input  logic sec_lock,
    output logic accept
);

    logic locked;

    always_comb begin
        locked = prot_sel ? sec_lock : blk_lock;
        accept = wel_i & qe_i & ~locked;
    end

endmodule

// File: rtl/quad_prog_rx.sv
module quad_prog_rx
    import quad_prog_rx_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PAGE_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [LANES-1:0]  sio,
    input  logic              wel_i,
    input  logic              qe_i,
    input  logic              prot_sel,
    input  logic              blk_lock,
    input  logic              sec_lock,
    input  logic [7:0]        buf_old,
    output logic [ADDR_W-1:0] lock_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wel_clr
);

    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);

    rx_state_e        state, nxt;
    logic             rise;
    logic             accept;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       cmd_q;
    logic [LANES-1:0] hi_q;
    logic [7:0]       byte_q;
    logic             wrote_q;
    logic             load_nib;
    logic             step;
    logic [ADDR_W-1:0] cur_addr;

    quad_prog_rx_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .sclk_rise (rise)
    );

    quad_prog_rx_gate u_gate (
        .wel_i    (wel_i),
        .qe_i     (qe_i),
        .prot_sel (prot_sel),
        .blk_lock (blk_lock),
        .sec_lock (sec_lock),
        .accept   (accept)
    );

    assign load_nib = !cs_n && rise && (state == S_ADDR);
    assign step     = !cs_n && rise && (state == S_DLO);

    quad_prog_rx_addr #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .NIB_W  (LANES)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_nib),
        .nib      (sio),
        .advance  (step),
        .cur_addr (cur_addr)
    );

    assign lock_addr = cur_addr;
    assign wr_data   = buf_old & byte_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next-state selection
    always_comb begin
        nxt = state;
        if (cs_n) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  nxt = S_CMD;
                S_CMD:   if (rise && cnt == CMD_LAST)
                             nxt = ({cmd_q[6:0], sio[0]} == QPP_CMD) ? S_ADDR : S_SKIP;
                S_ADDR:  if (rise && cnt == ADDR_LAST) nxt = S_CHECK;
                S_CHECK: nxt = accept ? S_DHI : S_SKIP;
                S_DHI:   if (rise) nxt = S_DLO;
                S_DLO:   if (rise) nxt = S_DHI;
                S_SKIP:  nxt = S_SKIP;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            cmd_q   <= '0;
            hi_q    <= '0;
            byte_q  <= '0;
            wrote_q <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wel_clr <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            wel_clr <= 1'b0;
            if (cs_n) begin
                if ((state == S_DHI || state == S_DLO) && wrote_q)
                    wel_clr <= 1'b1;
                wrote_q <= 1'b0;
                cnt     <= '0;
            end else begin
                unique case (state)
                    S_CMD: if (rise) begin
                        cmd_q <= {cmd_q[6:0], sio[0]};
                        cnt   <= cnt + 1'b1;
                    end
                    S_ADDR: if (rise) cnt <= cnt + 1'b1;
                    S_DHI:  if (rise) hi_q <= sio;
                    S_DLO:  if (rise) begin
                        byte_q  <= {hi_q, sio};
                        wr_addr <= cur_addr;
                        wr_en   <= 1'b1;
                        wrote_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: a strobe follows only a low-nibble edge
    p_wr_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(state) == S_DLO));

    // R7, R8: data phase is entered only with write enable and quad enable
    p_gate_r7_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DHI && $past(state) == S_CHECK) |-> $past(wel_i && qe_i));

    // R9: data phase is entered only for an unlocked page
    p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DHI && $past(state) == S_CHECK) |->
            $past(prot_sel ? !sec_lock : !blk_lock));

    // R11: latch clear only right after chip select was seen high
    p_wel_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |-> ($past(cs_n) && state == S_IDLE));

    p_wel_clr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !wel_clr);

endmodule

// File: tb/test_quad_prog_rx.sv
`timescale 1ns/1ps
module test_quad_prog_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic [3:0]  sio = 4'h0;
    logic        wel_i = 1'b1, qe_i = 1'b1, prot_sel = 1'b0;
    logic        blk_lock = 1'b0, sec_lock = 1'b0;
    logic [7:0]  buf_old;
    logic [23:0] lock_addr, wr_addr;
    logic        wr_en, wel_clr;
    logic [7:0]  wr_data;

    logic [7:0]  mem [0:255];
    logic [23:0] log_addr [0:511];
    logic [7:0]  log_data [0:511];
    int          wcnt = 0, clrcnt = 0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    assign buf_old = mem[wr_addr[7:0]];

    quad_prog_rx i_quad_prog_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sio(sio),
        .wel_i(wel_i), .qe_i(qe_i), .prot_sel(prot_sel),
        .blk_lock(blk_lock), .sec_lock(sec_lock), .buf_old(buf_old),
        .lock_addr(lock_addr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wel_clr(wel_clr)
    );

    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (wcnt < 512) begin
                log_addr[wcnt] = wr_addr;
                log_data[wcnt] = wr_data;
            end
            wcnt = wcnt + 1;
        end
        if (rst_n && wel_clr) clrcnt = clrcnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(input int k, input logic [7:0] base);
        return 8'(base + k * 37);
    endfunction

    task automatic tick(input logic [3:0] nib);
        @(negedge clk); sclk = 1'b0; sio = nib;
        @(negedge clk);
        @(negedge clk); sclk = 1'b1;
        @(negedge clk);
    endtask

    // cmd_bits / addr_nibs below full length cut the frame short
    task automatic frame(input logic [7:0] cmd, input int cmd_bits, input logic [23:0] addr,
                         input int addr_nibs, input int nbytes, input int extra_nibs,
                         input bit mode3, input logic [7:0] base);
        wcnt = 0; clrcnt = 0;
        @(negedge clk); sclk = mode3;
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < cmd_bits; i++) tick({3'b101, cmd[7-i]});
        for (int i = 0; i < addr_nibs; i++) tick(addr[23-4*i -: 4]);
        for (int k = 0; k < nbytes; k++) begin
            tick(dbyte(k, base)[7:4]);
            tick(dbyte(k, base)[3:0]);
        end
        for (int i = 0; i < extra_nibs; i++) tick(4'hA);
        @(negedge clk); if (!mode3) sclk = 1'b0;
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        chk(wr_en === 1'b0, "R1 wr_en", 32'(wr_en), 0);
        chk(wel_clr === 1'b0, "R1 wel_clr", 32'(wel_clr), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7 R8 R9 R12: full sweep of gating inputs
        for (int c = 0; c < 32; c++) begin
            logic exp_w;
            wel_i = c[0]; qe_i = c[1]; prot_sel = c[2]; blk_lock = c[3]; sec_lock = c[4];
            exp_w = wel_i & qe_i & ~(prot_sel ? sec_lock : blk_lock);
            frame(8'h38, 8, 24'h123456, 6, 1, 0, c[0] ^ c[3], 8'(c));
            chk(wcnt == int'(exp_w), "R7 R8 R9 gate writes", 32'(wcnt), 32'(exp_w));
            chk(clrcnt == int'(exp_w), "R11 wel_clr after gate", 32'(clrcnt), 32'(exp_w));
            if (exp_w)
                chk(log_addr[0] == 24'h123456 && log_data[0] == dbyte(0, 8'(c)),
                    "R3 R4 single byte", {log_addr[0][23:0], log_data[0]}, {24'h123456, dbyte(0, 8'(c))});
        end
        wel_i = 1; qe_i = 1; prot_sel = 0; blk_lock = 0; sec_lock = 0;

        // R3 R4 R6 R12: 256 bytes from mid-page, both clock idle levels
        for (int m = 0; m < 2; m++) begin
            frame(8'h38, 8, 24'hA5C380, 6, 256, 0, m[0], 8'h11);
            chk(wcnt == 256, "R4 byte count", 32'(wcnt), 256);
            for (int k = 0; k < 256; k++) begin
                logic [23:0] ea;
                ea = {16'hA5C3, 8'(8'h80 + k)};
                chk(log_addr[k] == ea, "R6 address wrap", 32'(log_addr[k]), 32'(ea));
                chk(log_data[k] == dbyte(k, 8'h11), "R3 R4 data nibbles", 32'(log_data[k]), 32'(dbyte(k, 8'h11)));
            end
        end

        // R5: AND merge over a preset buffer
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 13) ^ 8'hC3;
        frame(8'h38, 8, 24'h0000F8, 6, 16, 0, 1'b0, 8'h5E);
        chk(wcnt == 16, "R5 byte count", 32'(wcnt), 16);
        for (int k = 0; k < 16; k++) begin
            logic [7:0] ea8, ed;
            ea8 = 8'(8'hF8 + k);
            ed = mem[ea8] & dbyte(k, 8'h5E);
            chk(log_data[k] == ed, "R5 and merge", 32'(log_data[k]), 32'(ed));
        end
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;

        // R2: wrong command codes
        frame(8'h3B, 8, 24'h001000, 6, 2, 0, 1'b0, 8'h00);
        chk(wcnt == 0 && clrcnt == 0, "R2 code 3B", 32'(wcnt + clrcnt), 0);
        frame(8'hB8, 8, 24'h001000, 6, 2, 0, 1'b1, 8'h00);
        chk(wcnt == 0 && clrcnt == 0, "R2 code B8", 32'(wcnt + clrcnt), 0);
        frame(8'h1C, 8, 24'h001000, 6, 2, 0, 1'b0, 8'h00);
        chk(wcnt == 0 && clrcnt == 0, "R2 shifted code", 32'(wcnt + clrcnt), 0);

        // R10: abort in command and address phases
        frame(8'h38, 4, 24'h002000, 0, 0, 0, 1'b0, 8'h00);
        chk(wcnt == 0 && clrcnt == 0, "R10 abort in command", 32'(wcnt + clrcnt), 0);
        frame(8'h38, 8, 24'h002000, 3, 0, 0, 1'b1, 8'h00);
        chk(wcnt == 0 && clrcnt == 0, "R10 abort in address", 32'(wcnt + clrcnt), 0);

        // R11: trailing partial byte, and no data at all
        frame(8'h38, 8, 24'h0030FF, 6, 2, 1, 1'b0, 8'h77);
        chk(wcnt == 2, "R11 partial byte dropped", 32'(wcnt), 2);
        chk(clrcnt == 1, "R11 wel_clr once", 32'(clrcnt), 1);
        chk(log_addr[1] == 24'h003000, "R6 wrap at FF", 32'(log_addr[1]), 32'h003000);
        frame(8'h38, 8, 24'h003000, 6, 0, 1, 1'b1, 8'h00);
        chk(wcnt == 0 && clrcnt == 0, "R11 no full byte", 32'(wcnt + clrcnt), 0);

        // R1: quiet after frames
        chk(wr_en === 1'b0 && wel_clr === 1'b0, "R1 idle outputs", {wr_en, wel_clr}, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule